// File: doc/BRIEF.md
# Flyback Fault Protection Manager

This block is the digital decision point for the protections of a primary-side regulated flyback controller. Analog comparators, outside the block, report per-pulse conditions: current over the cycle limit, current over the short-circuit level, a shorted zero-crossing sense pin, and output over- or under-voltage from the sampled output. Other inputs are level flags for supply over-voltage, supply under-voltage, thermal shutdown and a current-sense pin open/short. A soft-start-done flag and a one-microsecond tick complete the inputs. The block applies the qualification rule that belongs to each fault class. It then either keeps the power switch enabled or withdraws drive and asks for a restart of the simple or the double kind.

A request, once made, is held and drive stays off until the supply sequencer, which lies outside the block, pulses `restart_i`. That pulse clears the held request and every qualification counter and timer. The UVP blanking window then restarts from the next soft-start completion.

Top module: `flyback_fault_mgr`

## Requirements
- R1: After reset `drive_en_o` is 1 and `hiccup_o` is 0. The request codes are 0 = none, 1 = simple hiccup and 2 = double hiccup.
- R2: A pulse end with `ilim_i` set arms the overload timer. Once `OCP_TICKS` ticks have been counted while it is armed, drive drops and code 2 is issued in the cycle of the last tick. Further `ilim_i` pulses do not restart the count.
- R3: The overload timer disarms and clears only after `CLEAN_PULSES` consecutive pulse ends with neither `ilim_i` nor `scp_i` set. A pulse with only `scp_i` set restarts that clean count.
- R4: `scp_i` on `PULSE_QUAL` consecutive pulse ends gives code 2 on the last one. A pulse end without `scp_i` clears the count.
- R5: `zcd_short_i` and `vout_ovp_i` each give code 2 after `PULSE_QUAL` consecutive pulse ends with the flag set.
- R6: `vout_uvp_i` counts only once `ss_done_i` has been high for `UVP_BLANK_TICKS` ticks. After that, `PULSE_QUAL` consecutive flagged pulse ends give code 2. Flagged pulses inside the blanking window have no effect.
- R7: `vcc_ovp_i` or `tsd_i` held high for `FILT_TICKS` consecutive ticks gives code 2. A drop of the flag before that restarts its filter.
- R8: `vcc_uv_i` held high for `FILT_TICKS` consecutive ticks gives code 1.
- R9: `cs_pin_fault_i` gives code 2 and drops drive in the same cycle it is seen.
- R10: When a simple and a double cause qualify in the same cycle, code 2 is issued. Whenever a code is issued, `drive_en_o` is 0 in that same cycle.
- R11: A request is held, with drive off and further causes ignored, until `restart_i`. `restart_i` clears the request and every count, so partial progress made before it does not carry over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_end_i | input | 1 | One-cycle strobe at the end of each drive pulse; pulse flags valid with it |
| ilim_i | input | 1 | Peak current reached the cycle limit this pulse |
| scp_i | input | 1 | Current sense exceeded the short-circuit level this pulse |
| zcd_short_i | input | 1 | Zero-crossing pin stayed low after its blanking this pulse |
| vout_ovp_i | input | 1 | Sampled output above the over-voltage level this pulse |
| vout_uvp_i | input | 1 | Sampled output below the under-voltage level while falling, this pulse |
| vcc_ovp_i | input | 1 | Supply above its over-voltage level (level) |
| tsd_i | input | 1 | Die over temperature (level) |
| vcc_uv_i | input | 1 | Supply below its stop level (level) |
| cs_pin_fault_i | input | 1 | Current-sense pin open or shorted at start-up check |
| ss_done_i | input | 1 | Soft start complete (level) |
| tick_us_i | input | 1 | One-cycle strobe every microsecond |
| restart_i | input | 1 | Hiccup sequence done; clear request and counts |
| drive_en_o | output | 1 | Power switch drive allowed |
| hiccup_o | output | 2 | Restart request: 0 none, 1 simple, 2 double |

## Verification
The bench builds the block with `OCP_TICKS`=12, `FILT_TICKS`=3, `UVP_BLANK_TICKS`=8 and `PULSE_QUAL`=`CLEAN_PULSES`=4. The millisecond windows shrink to a handful of ticks, so every timer can be run to one tick short of its limit and then to the limit itself. At these sizes the bench also reaches clean-pulse release against a short-pulse interruption, filter glitches, unblanked versus blanked UVP pulses, same-tick simple/double conflicts and partial counts cut off by a restart. Expected request codes and the cycle of each drive drop are counted out from the requirements.

// File: rtl/fm_pkg.sv
package fm_pkg;
  typedef enum logic [1:0] {
    HIC_NONE   = 2'd0,
    HIC_SIMPLE = 2'd1,
    HIC_DOUBLE = 2'd2
  } hiccup_e;

  localparam int unsigned NUM_PQ = 4; // scp, zcd short, vout ovp, vout uvp
  localparam int unsigned NUM_LF = 3; // vcc ovp, tsd, vcc uv
  localparam int unsigned LF_UV  = 2; // index of the simple-hiccup filter
endpackage

// File: rtl/fm_pulse_qual.sv
module fm_pulse_qual #(
  parameter int unsigned QUAL = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic strobe_i,
  input  logic flag_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(QUAL + 1);
  logic [CW-1:0] cnt_q;

  assign fire_o = strobe_i & flag_i & (cnt_q == CW'(QUAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (strobe_i) begin
      if (!flag_i || fire_o) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fm_level_filter.sv
module fm_level_filter #(
  parameter int unsigned FILT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic flag_i,
  output logic fire_o
);
  localparam int unsigned CW = $clog2(FILT + 1);
  logic [CW-1:0] cnt_q;

  assign fire_o = flag_i & tick_i & (cnt_q == CW'(FILT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || !flag_i)  cnt_q <= '0;
    else if (tick_i && !fire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fm_overload_timer.sv
module fm_overload_timer #(
  parameter int unsigned OCP_TICKS    = 70000,
  parameter int unsigned CLEAN_PULSES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic strobe_i,
  input  logic ilim_i,
  input  logic scp_i,
  output logic fire_o
);
  localparam int unsigned TW = $clog2(OCP_TICKS + 1);
  localparam int unsigned KW = $clog2(CLEAN_PULSES + 1);

  logic          armed_q;
  logic [TW-1:0] tmr_q;
  logic [KW-1:0] clean_q;
  logic          release_w;

  assign release_w = strobe_i & armed_q & ~ilim_i & ~scp_i &
                     (clean_q == KW'(CLEAN_PULSES - 1));
  assign fire_o    = armed_q & tick_i & (tmr_q == TW'(OCP_TICKS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      clean_q <= '0;
      tmr_q   <= '0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      clean_q <= '0;
      tmr_q   <= '0;
    end else begin
      if (strobe_i) begin
        if (ilim_i) begin
          armed_q <= 1'b1;
          clean_q <= '0;
        end else if (scp_i) begin
          clean_q <= '0;
        end else if (release_w) begin
          armed_q <= 1'b0;
          clean_q <= '0;
        end else if (armed_q) begin
          clean_q <= clean_q + 1'b1;
        end
      end
      if (release_w || !armed_q)     tmr_q <= '0;
      else if (tick_i && !fire_o)    tmr_q <= tmr_q + 1'b1;
    end
  end
endmodule

// File: rtl/fm_uvp_blank.sv
module fm_uvp_blank #(
  parameter int unsigned BLANK_TICKS = 76000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic ss_done_i,
  output logic armed_o
);
  localparam int unsigned BW = $clog2(BLANK_TICKS + 1);
  logic [BW-1:0] cnt_q;

  assign armed_o = (cnt_q == BW'(BLANK_TICKS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i || !ss_done_i)  cnt_q <= '0;
    else if (tick_i && !armed_o)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/flyback_fault_mgr.sv
module flyback_fault_mgr
  import fm_pkg::*;
#(
  parameter int unsigned PULSE_QUAL      = 4,
  parameter int unsigned CLEAN_PULSES    = 4,
  parameter int unsigned OCP_TICKS       = 70000,
  parameter int unsigned UVP_BLANK_TICKS = 76000,
  parameter int unsigned FILT_TICKS      = 10
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pulse_end_i,
  input  logic       ilim_i,
  input  logic       scp_i,
  input  logic       zcd_short_i,
  input  logic       vout_ovp_i,
  input  logic       vout_uvp_i,
  input  logic       vcc_ovp_i,
  input  logic       tsd_i,
  input  logic       vcc_uv_i,
  input  logic       cs_pin_fault_i,
  input  logic       ss_done_i,
  input  logic       tick_us_i,
  input  logic       restart_i,
  output logic       drive_en_o,
  output logic [1:0] hiccup_o
);
  hiccup_e            req_q;
  logic               faulted_w;
  logic               strobe_w;
  logic               uvp_armed_w;
  logic [NUM_PQ-1:0]  pq_flag_w, pq_fire_w;
  logic [NUM_LF-1:0]  lf_flag_w, lf_fire_w;
  logic               ocp_fire_w;
  logic               ev_double_w, ev_simple_w;
  hiccup_e            ev_code_w;

  assign faulted_w = (req_q != HIC_NONE);
  assign strobe_w  = pulse_end_i & ~faulted_w;

  fm_uvp_blank #(.BLANK_TICKS(UVP_BLANK_TICKS)) u_blank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (restart_i),
    .tick_i   (tick_us_i),
    .ss_done_i(ss_done_i),
    .armed_o  (uvp_armed_w)
  );

  assign pq_flag_w = {vout_uvp_i & uvp_armed_w, vout_ovp_i, zcd_short_i, scp_i};
  assign lf_flag_w = {vcc_uv_i, tsd_i, vcc_ovp_i};

  for (genvar g = 0; g < NUM_PQ; g++) begin : g_pq
    fm_pulse_qual #(.QUAL(PULSE_QUAL)) u_pq (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (restart_i),
      .strobe_i(strobe_w),
      .flag_i  (pq_flag_w[g]),
      .fire_o  (pq_fire_w[g])
    );
  end

  for (genvar g = 0; g < NUM_LF; g++) begin : g_lf
    fm_level_filter #(.FILT(FILT_TICKS)) u_lf (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (restart_i | faulted_w),
      .tick_i(tick_us_i),
      .flag_i(lf_flag_w[g]),
      .fire_o(lf_fire_w[g])
    );
  end

  fm_overload_timer #(
    .OCP_TICKS   (OCP_TICKS),
    .CLEAN_PULSES(CLEAN_PULSES)
  ) u_ocp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (restart_i),
    .tick_i  (tick_us_i & ~faulted_w),
    .strobe_i(strobe_w),
    .ilim_i  (ilim_i),
    .scp_i   (scp_i),
    .fire_o  (ocp_fire_w)
  );

  always_comb begin
    ev_double_w = 1'b0;
    ev_simple_w = 1'b0;
    if (!faulted_w) begin
      ev_double_w = (|pq_fire_w) | ocp_fire_w | cs_pin_fault_i;
      for (int i = 0; i < NUM_LF; i++) begin
        if (i == LF_UV) ev_simple_w = ev_simple_w | lf_fire_w[i];
        else            ev_double_w = ev_double_w | lf_fire_w[i];
      end
    end
    if (ev_double_w)      ev_code_w = HIC_DOUBLE;
    else if (ev_simple_w) ev_code_w = HIC_SIMPLE;
    else                  ev_code_w = HIC_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  req_q <= HIC_NONE;
    else if (restart_i)           req_q <= HIC_NONE;
    else if (ev_code_w != HIC_NONE) req_q <= ev_code_w;
  end

  assign hiccup_o   = faulted_w ? req_q : ev_code_w;
  assign drive_en_o = ~faulted_w & (ev_code_w == HIC_NONE);
endmodule

// File: rtl/fm_checker.sv
module fm_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_pin_fault_i,
  input logic       restart_i,
  input logic       drive_en_o,
  input logic [1:0] hiccup_o
);
  p_code_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hiccup_o != 2'd3);

  p_req_drops_drive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hiccup_o != 2'd0) |-> !drive_en_o);

  p_req_held_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hiccup_o != 2'd0 && !restart_i) |=> (hiccup_o == $past(hiccup_o)));

  p_drive_stays_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drive_en_o && !restart_i) |=> !drive_en_o);

  p_cs_fault_now_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_pin_fault_i |-> !drive_en_o);
endmodule

bind flyback_fault_mgr fm_checker u_fm_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_pin_fault_i(cs_pin_fault_i),
  .restart_i     (restart_i),
  .drive_en_o    (drive_en_o),
  .hiccup_o      (hiccup_o)
);

// File: tb/flyback_fault_mgr_bench.sv
module flyback_fault_mgr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL  = 4;
  localparam int CLEAN = 4;
  localparam int OCP   = 12;
  localparam int BLANK = 8;
  localparam int FILT  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_end = 0, ilim = 0, scp = 0, zcd = 0, vovp = 0, vuvp = 0;
  logic vcc_ovp = 0, tsd = 0, vcc_uv = 0, cs_fault = 0, ss_done = 0;
  logic tick = 0, restart = 0;
  logic drive_en;
  logic [1:0] hiccup;
  logic obs_en;
  logic [1:0] obs_code;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flyback_fault_mgr #(
    .PULSE_QUAL(QUAL), .CLEAN_PULSES(CLEAN), .OCP_TICKS(OCP),
    .UVP_BLANK_TICKS(BLANK), .FILT_TICKS(FILT)
  ) u_flyback_fault_mgr (
    .clk_i(clk), .rst_ni(rst_n), .pulse_end_i(pulse_end), .ilim_i(ilim),
    .scp_i(scp), .zcd_short_i(zcd), .vout_ovp_i(vovp), .vout_uvp_i(vuvp),
    .vcc_ovp_i(vcc_ovp), .tsd_i(tsd), .vcc_uv_i(vcc_uv),
    .cs_pin_fault_i(cs_fault), .ss_done_i(ss_done), .tick_us_i(tick),
    .restart_i(restart), .drive_en_o(drive_en), .hiccup_o(hiccup)
  );

  // pf bits: 0 ilim, 1 scp, 2 zcd, 3 vout ovp, 4 vout uvp
  task automatic cyc(input logic [4:0] pf, input logic pe, input logic tk, input logic rs);
    @(negedge clk);
    {vuvp, vovp, zcd, scp, ilim} = pe ? pf : 5'b0;
    pulse_end = pe; tick = tk; restart = rs;
    #1;
    obs_en = drive_en; obs_code = hiccup;
    @(posedge clk);
    #1;
    pulse_end = 0; tick = 0; restart = 0;
    {vuvp, vovp, zcd, scp, ilim} = 5'b0;
  endtask

  task automatic pulse(input logic [4:0] pf); cyc(pf, 1'b1, 1'b0, 1'b0); endtask
  task automatic tk();                         cyc(5'b0, 1'b0, 1'b1, 1'b0); endtask
  task automatic rst_hic();                    cyc(5'b0, 1'b0, 1'b0, 1'b1); endtask
  task automatic idle();                       cyc(5'b0, 1'b0, 1'b0, 1'b0); endtask

  task automatic expect_obs(input string req, input logic en_e, input logic [1:0] code_e);
    checks++;
    if (obs_en !== en_e || obs_code !== code_e) begin
      errors++;
      $display("FAIL %s: drive_en=%0b hiccup=%0d expected drive_en=%0b hiccup=%0d",
               req, obs_en, obs_code, en_e, code_e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(); expect_obs("R1 reset", 1, 0);

    // R4: winding short counting
    for (int n = 0; n < QUAL - 1; n++) pulse(5'b00010);
    expect_obs("R4 below count", 1, 0);
    pulse(5'b00000);
    for (int n = 0; n < QUAL - 1; n++) pulse(5'b00010);
    expect_obs("R4 count cleared by clean pulse", 1, 0);
    pulse(5'b00010); expect_obs("R4 qualify", 0, 2);
    idle(); expect_obs("R11 held", 0, 2);
    rst_hic(); idle(); expect_obs("R11 restart clears", 1, 0);

    // R11: partial count dropped by restart
    for (int n = 0; n < QUAL - 1; n++) pulse(5'b00010);
    rst_hic();
    pulse(5'b00010); expect_obs("R11 count cleared", 1, 0);
    rst_hic();

    // R5: zcd short and vout ovp
    for (int b = 2; b <= 3; b++) begin
      for (int n = 0; n < QUAL - 1; n++) pulse(5'(1 << b));
      expect_obs("R5 below count", 1, 0);
      pulse(5'(1 << b)); expect_obs("R5 qualify", 0, 2);
      rst_hic();
    end

    // R2/R3: overload timer
    pulse(5'b00001);
    for (int n = 0; n < OCP - 1; n++) tk();
    expect_obs("R2 one tick short", 1, 0);
    tk(); expect_obs("R2 timer expiry", 0, 2);
    rst_hic();
    pulse(5'b00001);
    for (int n = 0; n < OCP - 1; n++) tk();
    for (int n = 0; n < CLEAN - 1; n++) pulse(5'b00000);
    tk(); expect_obs("R3 too few clean pulses keep timer", 0, 2);
    rst_hic();
    pulse(5'b00001);
    for (int n = 0; n < OCP - 1; n++) tk();
    for (int n = 0; n < CLEAN; n++) pulse(5'b00000);
    for (int n = 0; n < OCP + 2; n++) tk();
    expect_obs("R3 clean pulses release timer", 1, 0);
    pulse(5'b00001);
    for (int n = 0; n < OCP - 1; n++) tk();
    for (int n = 0; n < CLEAN - 1; n++) pulse(5'b00000);
    pulse(5'b00010);
    for (int n = 0; n < CLEAN - 1; n++) pulse(5'b00000);
    expect_obs("R3 scp pulse restarts clean count", 1, 0);
    tk(); expect_obs("R3 timer still armed", 0, 2);
    rst_hic();

    // R6: uvp blanking
    ss_done = 1;
    for (int n = 0; n < BLANK - 1; n++) tk();
    for (int n = 0; n < QUAL; n++) pulse(5'b10000);
    expect_obs("R6 blanked", 1, 0);
    tk();
    for (int n = 0; n < QUAL - 1; n++) pulse(5'b10000);
    expect_obs("R6 below count", 1, 0);
    pulse(5'b10000); expect_obs("R6 qualify", 0, 2);
    ss_done = 0;
    rst_hic();

    // R7: supply ovp filter with glitch, then thermal
    vcc_ovp = 1;
    for (int n = 0; n < FILT - 1; n++) tk();
    vcc_ovp = 0; idle(); vcc_ovp = 1;
    for (int n = 0; n < FILT - 1; n++) tk();
    expect_obs("R7 glitch restarts filter", 1, 0);
    tk(); expect_obs("R7 supply ovp", 0, 2);
    vcc_ovp = 0; rst_hic();
    tsd = 1;
    for (int n = 0; n < FILT - 1; n++) tk();
    expect_obs("R7 tsd one short", 1, 0);
    tk(); expect_obs("R7 thermal", 0, 2);
    tsd = 0; rst_hic();

    // R8 and R11 ignore
    vcc_uv = 1;
    for (int n = 0; n < FILT - 1; n++) tk();
    expect_obs("R8 one short", 1, 0);
    tk(); expect_obs("R8 simple", 0, 1);
    tsd = 1;
    for (int n = 0; n < FILT + 1; n++) tk();
    expect_obs("R11 later double ignored", 0, 1);
    vcc_uv = 0; tsd = 0; rst_hic();

    // R10 priority
    vcc_uv = 1; tsd = 1;
    for (int n = 0; n < FILT; n++) tk();
    expect_obs("R10 double wins", 0, 2);
    vcc_uv = 0; tsd = 0; rst_hic();

    // R9 cs pin fault
    idle(); expect_obs("R9 before", 1, 0);
    cs_fault = 1; idle(); expect_obs("R9 immediate", 0, 2);
    cs_fault = 0; idle(); expect_obs("R9 held", 0, 2);
    rst_hic(); idle(); expect_obs("R11 final clear", 1, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule